// File: doc/BRIEF.md
# Dual-Grant Round-Robin Output Allocator

This block is the output-port controller of a mesh router whose node carries two local cores. Six input ports can request the one output channel it owns: four direction ports and two local ports. The channel can move two packets in one cycle, so the controller can issue two grants per cycle. A primary round-robin stage picks one requester. A secondary round-robin stage works on the same requests with the primary winner removed, so it picks a different input. When two packets compete for the output, both can cross the link together.

The number of grants depends on how many slots are free in the downstream input buffer. With two or more free slots, both stages may grant. With exactly one free slot, only the primary stage may grant. With none, nothing is granted. Each stage keeps its own rotating priority pointer, so the service stays fair. Requests that XY routing can never produce for this output are discarded at the inputs. The set of such requests is fixed by the output's own direction.

Grants are a combinational function of the request vector, the free-slot count and the two registered pointers. The requests are plain level signals, not a valid/ready stream. An input keeps its request raised until it sees its bit in either grant vector. The only back-pressure is the free-slot count.

Top module: `dual_grant_out_alloc`

## Requirements
- R1: The primary stage grants the first legal requester found when scanning upward from its pointer and wrapping past the top index. When it grants, `gnt_a` is one-hot and `gnt_a_vld` is high. Otherwise `gnt_a` is all zeros and `gnt_a_vld` is low.
- R2: Each stage's pointer is 0 after reset. In a cycle where that stage grants input k, its pointer becomes k+1, or 0 when k is the top index. In any cycle where it does not grant, the pointer holds.
- R3: The secondary stage uses the same upward, wrapping scan from its own pointer. It scans the legal requests with the primary winner removed.
- R4: The two grant vectors never share a bit. The secondary grant is valid only together with a primary grant. With a single legal requester, only the primary stage grants.
- R5: When `free_slots` equals 1, the secondary stage issues no grant and its pointer holds.
- R6: When `free_slots` equals 0, neither stage grants and both pointers hold.
- R7: The port index order is north=0, east=1, south=2, west=3, local0=4, local1=5. A request from the input whose index equals `OUT_PORT` is ignored. When `OUT_PORT` is east or west, requests from north and south are also ignored. An ignored request never appears in either grant and does not move a pointer.
- R8: Grants appear in the same cycle as the requests that cause them. With no legal request raised, both valid outputs are low.
- R9: Consider a legal requester that holds its request and counts only cycles with at least one free slot. Such a requester is granted within `NUM_IN` of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointers |
| req_in | input | NUM_IN | Per-input request for this output, one bit each |
| free_slots | input | SLOT_W | Free slots in the downstream input buffer |
| gnt_a | output | NUM_IN | Primary grant, one-hot |
| gnt_a_vld | output | 1 | Primary grant issued |
| gnt_b | output | NUM_IN | Secondary grant, one-hot, never equal to `gnt_a` |
| gnt_b_vld | output | 1 | Secondary grant issued |

## Verification
The grants are due in the same cycle as their inputs. The bench drives requests and the slot count just after a rising edge and compares the grants at the following falling edge. Pointer effects show up one edge later. The bench advances its own model pointers only after each comparison, so every cycle's expected grants come from the previous cycles' grants. The wait bound is measured per input in cycles with free slots. It is checked at the moment each grant arrives.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int MAX_PORTS = 16;
  localparam int PORT_N  = 0;
  localparam int PORT_E  = 1;
  localparam int PORT_S  = 2;
  localparam int PORT_W  = 3;

  // Inputs that XY routing can route toward a given output.
  function automatic logic [MAX_PORTS-1:0] legal_mask(int out_port, int n);
    logic [MAX_PORTS-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[i] = 1'b1;
      if (i == out_port) m[i] = 1'b0;
      if ((out_port == PORT_E || out_port == PORT_W) &&
          (i == PORT_N || i == PORT_S)) m[i] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] ptr,
  output logic [N-1:0]         onehot,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int PW = $clog2(N);

  int j;
  always_comb begin
    onehot = '0;
    any    = 1'b0;
    idx    = '0;
    j      = 0;
    for (int i = 0; i < N; i++) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any       = 1'b1;
        onehot[j] = 1'b1;
        idx       = PW'(j);
      end
    end
  end
endmodule

// File: rtl/rr_stage.sv
module rr_stage #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         vld
);
  localparam int PW = $clog2(N);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;
  logic [N-1:0]  pick_oh;
  logic          pick_any;
  logic [PW-1:0] pick_idx;

  rr_pick #(.N(N)) u_pick (
    .req    (req),
    .ptr    (ptr_q),
    .onehot (pick_oh),
    .any    (pick_any),
    .idx    (pick_idx)
  );

  assign vld     = en & pick_any;
  assign gnt     = en ? pick_oh : '0;
  assign ptr_nxt = (pick_idx == PW'(N - 1)) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (vld) ptr_q <= ptr_nxt;
  end

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(ptr_q));
  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < N);
  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $countones(gnt) == 1);
  // R1
  gnt_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/dual_grant_out_alloc.sv
module dual_grant_out_alloc #(
  parameter int NUM_IN   = 6,
  parameter int OUT_PORT = 4,
  parameter int SLOT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_in,
  input  logic [SLOT_W-1:0] free_slots,
  output logic [NUM_IN-1:0] gnt_a,
  output logic              gnt_a_vld,
  output logic [NUM_IN-1:0] gnt_b,
  output logic              gnt_b_vld
);
  localparam logic [alloc_pkg::MAX_PORTS-1:0] LEGAL_FULL =
    alloc_pkg::legal_mask(OUT_PORT, NUM_IN);
  localparam logic [NUM_IN-1:0] LEGAL = LEGAL_FULL[NUM_IN-1:0];

  logic [NUM_IN-1:0] legal_req;
  logic [NUM_IN-1:0] req_b;
  logic              en_a;
  logic              en_b;

  assign legal_req = req_in & LEGAL;
  assign en_a      = free_slots != '0;
  assign en_b      = free_slots > SLOT_W'(1);
  assign req_b     = legal_req & ~gnt_a;

  rr_stage #(.N(NUM_IN)) u_stage_a (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_a),
    .req   (legal_req),
    .gnt   (gnt_a),
    .vld   (gnt_a_vld)
  );

  rr_stage #(.N(NUM_IN)) u_stage_b (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_b),
    .req   (req_b),
    .gnt   (gnt_b),
    .vld   (gnt_b_vld)
  );

  // R4
  distinct_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a & gnt_b) == '0);
  // R4
  b_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_b_vld |-> gnt_a_vld);
  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots < SLOT_W'(2)) |-> !gnt_b_vld);
  // R6
  no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots == '0) |-> !gnt_a_vld);
  // R7
  legal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_a | gnt_b) & ~req_in) == '0);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_req == '0) |-> !gnt_a_vld);
endmodule

// File: tb/dual_grant_out_alloc_tb.sv
module dual_grant_out_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 6;
  localparam int OUTP       = 4;
  localparam int SW         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_in = '0;
  logic [SW-1:0] free_slots = '0;
  logic [N-1:0]  gnt_a, gnt_b;
  logic          gnt_a_vld, gnt_b_vld;

  int checks = 0;
  int fails  = 0;
  int ptr_a  = 0;
  int ptr_b  = 0;
  int wait_cnt [N];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_grant_out_alloc #(.NUM_IN(N), .OUT_PORT(OUTP), .SLOT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .free_slots(free_slots),
    .gnt_a(gnt_a), .gnt_a_vld(gnt_a_vld), .gnt_b(gnt_b), .gnt_b_vld(gnt_b_vld)
  );

  // R7: output local0 (index 4) accepts every input except itself
  function automatic logic [N-1:0] legal_of();
    logic [N-1:0] m = '1;
    m[OUTP] = 1'b0;
    return m;
  endfunction

  function automatic int scan(logic [N-1:0] r, int p);
    for (int i = 0; i < N; i++) begin
      int k = (p + i) % N;
      if (r[k]) return k;
    end
    return -1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] r, logic [SW-1:0] f, string tag);
    logic [N-1:0] lr, ea, eb;
    int wa, wb;
    @(posedge clk); #1;
    req_in = r; free_slots = f;
    @(negedge clk);
    lr = r & legal_of();
    wa = (f >= 1) ? scan(lr, ptr_a) : -1;
    ea = (wa >= 0) ? (N'(1) << wa) : '0;
    wb = (f >= 2) ? scan(lr & ~ea, ptr_b) : -1;
    eb = (wb >= 0) ? (N'(1) << wb) : '0;
    chk({tag, " gnt_a"}, 32'(gnt_a), 32'(ea));
    chk({tag, " gnt_a_vld"}, 32'(gnt_a_vld), 32'(wa >= 0));
    chk({tag, " gnt_b"}, 32'(gnt_b), 32'(eb));
    chk({tag, " gnt_b_vld"}, 32'(gnt_b_vld), 32'(wb >= 0));
    // R9: bounded wait per legal requester, counted in cycles with a free slot
    for (int i = 0; i < N; i++) begin
      if (lr[i] && (gnt_a[i] || gnt_b[i])) begin
        chk("R9 wait bound", 32'(wait_cnt[i] < N), 32'd1);
        wait_cnt[i] = 0;
      end else if (lr[i] && f != 0) wait_cnt[i]++;
      else if (!lr[i]) wait_cnt[i] = 0;
    end
    if (wa >= 0) ptr_a = (wa + 1) % N;
    if (wb >= 0) ptr_b = (wb + 1) % N;
  endtask

  initial begin
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    void'($urandom(32'h1D5E_A11C));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 R2: after reset both pointers at 0 -> inputs 0 and 1
    step(6'b111111, 3'd7, "R8 reset");
    chk("R8 reset a", 32'(gnt_a), 32'h01);
    chk("R8 reset b", 32'(gnt_b), 32'h02);
    step(6'b000000, 3'd7, "R8 idle");
    // R4: single requester -> only primary
    step(6'b001000, 3'd7, "R4 single");
    chk("R4 single b_vld", 32'(gnt_b_vld), 32'd0);
    // R7: only the ignored own-port request
    step(6'b010000, 3'd7, "R7 own");
    chk("R7 own ignored", 32'(gnt_a_vld), 32'd0);
    step(6'b110000, 3'd7, "R7 own+l1");
    // R5: one free slot
    step(6'b101111, 3'd1, "R5 one slot");
    chk("R5 no b", 32'(gnt_b_vld), 32'd0);
    // R6: no free slot
    step(6'b101111, 3'd0, "R6 zero slot");
    chk("R6 no a", 32'(gnt_a_vld), 32'd0);
    // R1 R3: rotation under steady full load
    for (int c = 0; c < 12; c++) step(6'b101111, 3'd2, "R1 R3 rotate");
    // R9: persistent requesters with a single slot
    for (int c = 0; c < 20; c++) step(6'b100011, 3'd1, "R9 hold");
    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r = N'($urandom);
      logic [SW-1:0] f = ($urandom % 4 == 0) ? SW'($urandom % 2) : SW'($urandom);
      step(r, f, "R1 R3 random");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule